// File: doc/BRIEF.md
# Deferred-Read Block Memory Line Controller

This controller sits on one line of a shared data memory and handles data in whole blocks, not single words. Each block is named by a token. For every token a table keeps the block's start address in the line memory, its length in words, and a bit that says whether the block holds valid data ("full") or not ("empty"). A producer writes a block as a burst of words. The start address goes with the first word, and a flag marks the final word. The block is recorded as full only when that final word is accepted.

A consumer asks for a block by giving only its token. The request is never refused because the data is missing. Every accepted request goes into one pending queue in arrival order. The head of the queue is served as soon as its block is full. Serving a request streams the whole block on the output, in address order, tagged with the token, with a flag on the last word. A read issued before its data exists therefore waits in the queue. It is replayed when the producing write completes.

A release input clears the full bit of a token so that the block can be written again. Writes aimed at a block that is still full are discarded.

Top module: `fe_line_ctrl`

## Requirements
- R1: After reset, `out_valid` is 0 and `rd_req_ready` is 1. Every token is empty, so a request to any token produces no output until that token is written.
- R2: A write burst of N words to an empty token stores word i at start address + i. Here word 0 carries `wr_base` and word N-1 carries `wr_last` = 1. The burst records the token as full, with length N.
- R3: A request to a full token, taken from an empty queue by an idle streamer, produces its N words in address order. Each word carries `out_token` equal to the token, and `out_last` = 1 only on word N-1. The first word is presented two rising edges after the edge that accepted the request.
- R4: A request to an empty token is held, and so is a request that arrives while that token's burst is still being written. It is served once the burst's last word is accepted. Its first word appears two rising edges after that edge.
- R5: Requests are served strictly in arrival order. A later request for a full block waits behind an earlier one whose block is still empty.
- R6: Within a block, `out_valid` stays 1 on consecutive cycles. Between two served blocks there is exactly one cycle with `out_valid` = 0.
- R7: When QDEPTH requests are pending, `rd_req_ready` is 0. A request presented then is dropped and never served.
- R8: A release clears the token's full bit. Later requests wait until the token is written again, and then they receive the new contents and the new length.
- R9: Write words aimed at a full token are discarded. The stored data and the recorded length stay unchanged.
- R10: Several requests for the same block each receive a complete copy of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write word present |
| wr_token | input | TOK_W | Token of the block being written |
| wr_base | input | ADDR_W | Start address, used on the first word of a burst |
| wr_data | input | DATA_W | Write word |
| wr_last | input | 1 | Final word of the burst |
| rd_req_valid | input | 1 | Block read request present |
| rd_req_token | input | TOK_W | Token requested |
| rd_req_ready | output | 1 | Pending queue has room |
| rel_valid | input | 1 | Release request |
| rel_token | input | TOK_W | Token to mark empty |
| out_valid | output | 1 | Output word present |
| out_token | output | TOK_W | Token of the block being streamed |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Final word of the streamed block |

## Verification
The bench builds the block with its defaults: 16 tokens, a pending queue of 8, 16-bit words and a 256-word line. Because the queue holds only 8, eight requests to an empty token are enough to fill it. That makes both the back-pressure case and the dropped-request case reachable in a short test. The 16 tokens give room for distinct blocks in every scenario without reuse. Reuse is still covered, by releasing a token and writing it again.

// File: rtl/fe_pkg.sv
`timescale 1ns/1ps
package fe_pkg;
    localparam int DEF_TOKENS = 16;
    localparam int DEF_QDEPTH = 8;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_ADDR_W = 8;

    typedef enum logic {
        RD_IDLE   = 1'b0,
        RD_STREAM = 1'b1
    } rd_state_e;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/fe_blk_writer.sv
`timescale 1ns/1ps
module fe_blk_writer #(
    parameter int TOK_W  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [TOK_W-1:0]  wr_token,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              tok_full,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fill_en,
    output logic [TOK_W-1:0]  fill_tok,
    output logic [ADDR_W-1:0] fill_base,
    output logic [LEN_W-1:0]  fill_len
);
    logic              active_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              accept;
    logic [ADDR_W-1:0] cur_base;
    logic [LEN_W-1:0]  cur_off;

    always_comb begin
        accept    = wr_valid && !tok_full;
        cur_base  = active_q ? base_q : wr_base;
        cur_off   = active_q ? cnt_q : '0;
        mem_we    = accept;
        mem_addr  = cur_base + cur_off[ADDR_W-1:0];
        mem_wdata = wr_data;
        fill_en   = accept && wr_last;
        fill_tok  = wr_token;
        fill_base = cur_base;
        fill_len  = cur_off + LEN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else if (accept) begin
            if (wr_last) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                active_q <= 1'b1;
                base_q   <= cur_base;
                cnt_q    <= cur_off + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/fe_tok_table.sv
`timescale 1ns/1ps
module fe_tok_table #(
    parameter int N_TOKENS = 16,
    parameter int TOK_W    = 4,
    parameter int ADDR_W   = 8,
    parameter int LEN_W    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [TOK_W-1:0]  fill_tok,
    input  logic [ADDR_W-1:0] fill_base,
    input  logic [LEN_W-1:0]  fill_len,
    input  logic              rel_en,
    input  logic [TOK_W-1:0]  rel_tok,
    input  logic [TOK_W-1:0]  look_a_tok,
    output logic              look_a_full,
    input  logic [TOK_W-1:0]  look_b_tok,
    output logic              look_b_full,
    output logic [ADDR_W-1:0] look_b_base,
    output logic [LEN_W-1:0]  look_b_len
);
    typedef struct packed {
        logic              full;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
    } ent_t;

    ent_t tbl_q [N_TOKENS];

    always_comb begin
        look_a_full = tbl_q[look_a_tok].full;
        look_b_full = tbl_q[look_b_tok].full;
        look_b_base = tbl_q[look_b_tok].base;
        look_b_len  = tbl_q[look_b_tok].len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_TOKENS; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            if (rel_en) tbl_q[rel_tok].full <= 1'b0;
            if (fill_en) tbl_q[fill_tok] <= '{full: 1'b1, base: fill_base, len: fill_len};
        end
    end

    // R9: a fill only completes on a token that was empty
    assert_fill_on_empty_R9: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !tbl_q[fill_tok].full);

    // R8: a release without a coincident fill leaves the token empty
    assert_release_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (rel_en && !(fill_en && fill_tok == rel_tok)) |=> !tbl_q[$past(rel_tok)].full);
endmodule

// File: rtl/fe_pend_fifo.sv
`timescale 1ns/1ps
module fe_pend_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         not_full
);
    localparam int PW = fe_pkg::idx_w(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    always_comb begin
        dout      = slot_q[rp_q];
        not_empty = (cnt_q != '0);
        not_full  = (cnt_q != CW'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
            if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R7: no push into a full queue
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < CW'(DEPTH)));

    // R5: the streamer only takes from a non-empty queue
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q != '0));
endmodule

// File: rtl/fe_blk_reader.sv
`timescale 1ns/1ps
module fe_blk_reader
    import fe_pkg::*;
#(
    parameter int TOK_W  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_valid,
    input  logic [TOK_W-1:0]  head_tok,
    input  logic              head_full,
    input  logic [ADDR_W-1:0] head_base,
    input  logic [LEN_W-1:0]  head_len,
    output logic              pop,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              out_valid,
    output logic [TOK_W-1:0]  out_token,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    rd_state_e         st_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q, cnt_q;
    logic [TOK_W-1:0]  tok_q;
    logic              is_last;

    always_comb begin
        pop     = (st_q == RD_IDLE) && q_valid && head_full;
        rd_addr = base_q + cnt_q[ADDR_W-1:0];
        is_last = (cnt_q == len_q - LEN_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= RD_IDLE;
            base_q    <= '0;
            len_q     <= '0;
            cnt_q     <= '0;
            tok_q     <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
            out_token <= '0;
        end else begin
            case (st_q)
                RD_IDLE: begin
                    out_valid <= 1'b0;
                    out_last  <= 1'b0;
                    if (pop) begin
                        st_q   <= RD_STREAM;
                        base_q <= head_base;
                        len_q  <= head_len;
                        tok_q  <= head_tok;
                        cnt_q  <= '0;
                    end
                end
                RD_STREAM: begin
                    out_valid <= 1'b1;
                    out_data  <= rd_data;
                    out_last  <= is_last;
                    out_token <= tok_q;
                    cnt_q     <= cnt_q + LEN_W'(1);
                    if (is_last) st_q <= RD_IDLE;
                end
                default: st_q <= RD_IDLE;
            endcase
        end
    end

    // R6: no hole inside a block
    assert_block_contiguous_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    // R6: one idle cycle after each block
    assert_gap_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |=> !out_valid);
endmodule

// File: rtl/fe_line_ctrl.sv
`timescale 1ns/1ps
module fe_line_ctrl #(
    parameter int N_TOKENS = fe_pkg::DEF_TOKENS,
    parameter int QDEPTH   = fe_pkg::DEF_QDEPTH,
    parameter int DATA_W   = fe_pkg::DEF_DATA_W,
    parameter int ADDR_W   = fe_pkg::DEF_ADDR_W,
    localparam int TOK_W   = fe_pkg::idx_w(N_TOKENS),
    localparam int LEN_W   = ADDR_W + 1,
    localparam int MEM_DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [TOK_W-1:0]  wr_token,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              rd_req_valid,
    input  logic [TOK_W-1:0]  rd_req_token,
    output logic              rd_req_ready,
    input  logic              rel_valid,
    input  logic [TOK_W-1:0]  rel_token,
    output logic              out_valid,
    output logic [TOK_W-1:0]  out_token,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr, rd_addr;
    logic [DATA_W-1:0] mem_wdata, rd_data;
    logic              fill_en;
    logic [TOK_W-1:0]  fill_tok;
    logic [ADDR_W-1:0] fill_base;
    logic [LEN_W-1:0]  fill_len;
    logic              wr_tok_full;
    logic              q_valid, q_push, q_pop;
    logic [TOK_W-1:0]  head_tok;
    logic              head_full;
    logic [ADDR_W-1:0] head_base;
    logic [LEN_W-1:0]  head_len;
    logic [DATA_W-1:0] line_q [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (mem_we) line_q[mem_addr] <= mem_wdata;
    end

    assign rd_data = line_q[rd_addr];
    assign q_push  = rd_req_valid && rd_req_ready;

    fe_blk_writer #(.TOK_W(TOK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_writer (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_token(wr_token), .wr_base(wr_base),
        .wr_data(wr_data), .wr_last(wr_last), .tok_full(wr_tok_full),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .fill_en(fill_en), .fill_tok(fill_tok), .fill_base(fill_base), .fill_len(fill_len)
    );

    fe_tok_table #(.N_TOKENS(N_TOKENS), .TOK_W(TOK_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_table (
        .clk(clk), .rst(rst),
        .fill_en(fill_en), .fill_tok(fill_tok), .fill_base(fill_base), .fill_len(fill_len),
        .rel_en(rel_valid), .rel_tok(rel_token),
        .look_a_tok(wr_token), .look_a_full(wr_tok_full),
        .look_b_tok(head_tok), .look_b_full(head_full),
        .look_b_base(head_base), .look_b_len(head_len)
    );

    fe_pend_fifo #(.DEPTH(QDEPTH), .W(TOK_W)) u_queue (
        .clk(clk), .rst(rst),
        .push(q_push), .din(rd_req_token),
        .pop(q_pop), .dout(head_tok),
        .not_empty(q_valid), .not_full(rd_req_ready)
    );

    fe_blk_reader #(.TOK_W(TOK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_reader (
        .clk(clk), .rst(rst),
        .q_valid(q_valid), .head_tok(head_tok), .head_full(head_full),
        .head_base(head_base), .head_len(head_len),
        .pop(q_pop), .rd_addr(rd_addr), .rd_data(rd_data),
        .out_valid(out_valid), .out_token(out_token), .out_data(out_data), .out_last(out_last)
    );
endmodule

// File: tb/fe_line_ctrl_tb.sv
`timescale 1ns/1ps
module fe_line_ctrl_tb;
    localparam int TW = 4;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int QD = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [TW-1:0] wr_token = '0;
    logic [AW-1:0] wr_base = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_last = 1'b0;
    logic          rd_req_valid = 1'b0;
    logic [TW-1:0] rd_req_token = '0;
    logic          rd_req_ready;
    logic          rel_valid = 1'b0;
    logic [TW-1:0] rel_token = '0;
    logic          out_valid;
    logic [TW-1:0] out_token;
    logic [DW-1:0] out_data;
    logic          out_last;

    fe_line_ctrl u_dut (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_token(wr_token), .wr_base(wr_base),
        .wr_data(wr_data), .wr_last(wr_last),
        .rd_req_valid(rd_req_valid), .rd_req_token(rd_req_token), .rd_req_ready(rd_req_ready),
        .rel_valid(rel_valid), .rel_token(rel_token),
        .out_valid(out_valid), .out_token(out_token), .out_data(out_data), .out_last(out_last)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int            cap_n = 0;
    logic [DW-1:0] cap_data [1024];
    logic          cap_last [1024];
    logic [TW-1:0] cap_tok  [1024];
    int            cap_cyc  [1024];

    always @(negedge clk) begin
        if (!rst && out_valid && cap_n < 1024) begin
            cap_data[cap_n] = out_data;
            cap_last[cap_n] = out_last;
            cap_tok[cap_n]  = out_token;
            cap_cyc[cap_n]  = cyc;
            cap_n = cap_n + 1;
        end
    end

    int vectors = 0;
    int miscompares = 0;
    int wr_mark = 0;
    int req_mark = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] wv(input int seed, input int i);
        return DW'(seed + i * 3);
    endfunction

    task automatic write_block(input int tok, input int base, input int n, input int seed, input int mid_tok);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_token = TW'(tok);
            wr_base  = AW'(base);
            wr_data  = wv(seed, i);
            wr_last  = (i == n - 1);
            if (mid_tok >= 0 && i == 1) begin
                rd_req_valid = 1'b1;
                rd_req_token = TW'(mid_tok);
            end else begin
                rd_req_valid = 1'b0;
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last = 1'b0;
        rd_req_valid = 1'b0;
        wr_mark = cyc;
    endtask

    task automatic request(input int tok);
        @(negedge clk);
        rd_req_valid = 1'b1;
        rd_req_token = TW'(tok);
        @(negedge clk);
        rd_req_valid = 1'b0;
        req_mark = cyc;
    endtask

    task automatic wait_caps(input int target);
        for (int k = 0; k < 400; k++) begin
            if (cap_n >= target) break;
            @(negedge clk);
        end
    endtask

    task automatic check_block(input int idx, input int tok, input int seed, input int n, input string req);
        check(int'(cap_tok[idx]) == tok, req, int'(cap_tok[idx]), tok);
        for (int i = 0; i < n; i++) begin
            check(cap_data[idx + i] == wv(seed, i), req, int'(cap_data[idx + i]), int'(wv(seed, i)));
            check(cap_last[idx + i] == (i == n - 1), req, int'(cap_last[idx + i]), int'(i == n - 1));
        end
    endtask

    // R1, R4: reset state; a request to an unwritten token waits
    task automatic test_reset_state();
        int b;
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(rd_req_ready == 1'b1, "R1 ready after reset", int'(rd_req_ready), 1);
        b = cap_n;
        request(5);
        repeat (20) @(negedge clk);
        check(cap_n == b, "R1 no output for empty token", cap_n - b, 0);
        write_block(5, 100, 2, 40, -1);
        wait_caps(b + 2);
        check_block(b, 5, 40, 2, "R4 deferred block");
        check(cap_cyc[b] == wr_mark + 2, "R4 latency after last write", cap_cyc[b], wr_mark + 2);
    endtask

    // R2, R3: write then read a full block
    task automatic test_direct();
        int b;
        write_block(1, 10, 4, 100, -1);
        b = cap_n;
        request(1);
        wait_caps(b + 4);
        check_block(b, 1, 100, 4, "R2 R3 stored block");
        check(cap_cyc[b] == req_mark + 2, "R3 latency", cap_cyc[b], req_mark + 2);
        check(cap_cyc[b + 3] == cap_cyc[b] + 3, "R6 contiguous words", cap_cyc[b + 3], cap_cyc[b] + 3);
    endtask

    // R4, R6, R10: reads before and during a write, several copies
    task automatic test_deferred();
        int b;
        b = cap_n;
        request(2);
        request(2);
        write_block(2, 30, 3, 200, 2);
        wait_caps(b + 9);
        check(cap_cyc[b] == wr_mark + 2, "R4 first copy latency", cap_cyc[b], wr_mark + 2);
        check_block(b, 2, 200, 3, "R10 copy 1");
        check_block(b + 3, 2, 200, 3, "R10 copy 2");
        check_block(b + 6, 2, 200, 3, "R4 R10 copy queued during write");
        check(cap_cyc[b + 3] == cap_cyc[b + 2] + 2, "R6 one idle cycle", cap_cyc[b + 3], cap_cyc[b + 2] + 2);
        check(cap_cyc[b + 6] == cap_cyc[b + 5] + 2, "R6 one idle cycle", cap_cyc[b + 6], cap_cyc[b + 5] + 2);
    endtask

    // R5: arrival order with a blocked head
    task automatic test_order();
        int b;
        b = cap_n;
        request(3);
        request(1);
        repeat (10) @(negedge clk);
        check(cap_n == b, "R5 full block waits behind empty head", cap_n - b, 0);
        write_block(3, 80, 3, 700, -1);
        wait_caps(b + 7);
        check_block(b, 3, 700, 3, "R5 first in order");
        check_block(b + 3, 1, 100, 4, "R5 second in order");
    endtask

    // R7: full queue deasserts ready and drops requests
    task automatic test_queue_full();
        int b;
        b = cap_n;
        for (int i = 0; i < QD; i++) request(4);
        check(rd_req_ready == 1'b0, "R7 ready low when queue full", int'(rd_req_ready), 0);
        @(negedge clk);
        rd_req_valid = 1'b1;
        rd_req_token = TW'(1);
        @(negedge clk);
        rd_req_valid = 1'b0;
        write_block(4, 200, 2, 500, -1);
        wait_caps(b + 2 * QD);
        repeat (40) @(negedge clk);
        check(cap_n == b + 2 * QD, "R7 dropped request not served", cap_n - b, 2 * QD);
        for (int i = 0; i < QD; i++) check_block(b + 2 * i, 4, 500, 2, "R7 queued blocks");
        check(rd_req_ready == 1'b1, "R7 ready back after drain", int'(rd_req_ready), 1);
    endtask

    // R9: write to a full token is ignored
    task automatic test_ignore_write();
        int b;
        write_block(1, 60, 2, 900, -1);
        b = cap_n;
        request(1);
        wait_caps(b + 4);
        repeat (10) @(negedge clk);
        check(cap_n == b + 4, "R9 length unchanged", cap_n - b, 4);
        check_block(b, 1, 100, 4, "R9 data unchanged");
    endtask

    // R8: release then rewrite
    task automatic test_release();
        int b;
        @(negedge clk);
        rel_valid = 1'b1;
        rel_token = TW'(1);
        @(negedge clk);
        rel_valid = 1'b0;
        b = cap_n;
        request(1);
        repeat (15) @(negedge clk);
        check(cap_n == b, "R8 released token waits", cap_n - b, 0);
        write_block(1, 40, 6, 300, -1);
        wait_caps(b + 6);
        check_block(b, 1, 300, 6, "R8 new contents");
        check(cap_cyc[b] == wr_mark + 2, "R8 R4 latency after rewrite", cap_cyc[b], wr_mark + 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset_state();
        test_direct();
        test_deferred();
        test_order();
        test_queue_full();
        test_ignore_write();
        test_release();
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(1_000_000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule